// File: doc/BRIEF.md
# Parallel-Port Host Mailbox and Data Selector

This block sits between a host on a parallel-port style bus and the internal logic of an acquisition device. Two host control lines pick what the block places on the eight data lines: buffered or live sample bytes from one of two channels, a single-byte mailbox shared with an internal controller, or a fixed identification byte. The host can probe for the device by selecting the identification pattern and checking for `0x55`.

The mailbox is half duplex. A byte written by one side is visible only to the other side. The writer itself reads zero until the opposite side writes. A reader therefore treats zero as "nothing new", and zero cannot be sent as a message. The host strobe does two jobs. With the mailbox selected and the host driving the bus, it stores the host's byte. With a channel selected, it advances that channel's readout. In scroll mode the channel selections show live converter values and the strobe does not advance anything.

All host lines are asynchronous to the block clock and pass through a synchronizer first. The data lines are driven only while the host has released them.

Top module: `pport_mbox_mux`

## Requirements
- R1: The selection code is {host_mbox_sel, host_alt_chan}. Code 00 drives channel A, 01 drives channel B, 10 drives the host view of the mailbox, and 11 drives the constant 0x55. host_data_o reflects a new selection within SYNC_STAGES+1 clock cycles.
- R2: host_data_oe is 1 exactly when the synchronized host_dir_in is 1 (the host has released the lines). It is 0 after reset.
- R3: A rising strobe edge with code 10 and host_dir_in=0 stores host_data_i. After that, ctl_rdata shows the byte and the host view of the mailbox reads 0.
- R4: A ctl_wr pulse stores ctl_wdata. After that, the host view shows the byte and ctl_rdata reads 0. If both sides write in the same cycle, the controller's write is kept.
- R5: After reset both mailbox views read 0.
- R6: A rising strobe edge with code 00 gives one cha_adv pulse, and with code 01 gives one chb_adv pulse, when scroll_mode is 0. The two pulses are never high together.
- R7: With scroll_mode=1, codes 00 and 01 drive cha_live and chb_live instead of the buffered bytes, and strobes produce no advance pulse.
- R8: A strobe with code 11, or with code 10 while host_dir_in=1, changes neither mailbox view and produces no advance pulse.
- R9: One strobe gives at most one event, however long it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_alt_chan | input | 1 | Host control, low bit of the selection code |
| host_mbox_sel | input | 1 | Host control, high bit of the selection code |
| host_strobe | input | 1 | Host strobe; its rising edge acts |
| host_dir_in | input | 1 | 1 when the host has released the data lines |
| host_data_i | input | DATA_W | Byte driven by the host |
| host_data_o | output | DATA_W | Byte driven toward the host |
| host_data_oe | output | 1 | Output enable for host_data_o |
| scroll_mode | input | 1 | Selects live channel bytes and suppresses advance |
| cha_buf | input | DATA_W | Buffered byte from channel A |
| chb_buf | input | DATA_W | Buffered byte from channel B |
| cha_live | input | DATA_W | Live byte from channel A |
| chb_live | input | DATA_W | Live byte from channel B |
| cha_adv | output | 1 | One-cycle advance for channel A readout |
| chb_adv | output | 1 | One-cycle advance for channel B readout |
| ctl_wr | input | 1 | Controller mailbox write |
| ctl_wdata | input | DATA_W | Controller mailbox byte |
| ctl_rdata | output | DATA_W | Controller view of the mailbox |

## Verification
A wrong owner flag in the mailbox shows up at once as a nonzero byte on the writer's own view. Depending on the path, it appears on ctl_rdata in the next cycle or on host_data_o a few cycles after the mailbox is selected. A bad edge detector or a wrong selection decode shows up as a missing, doubled or misdirected advance pulse about three cycles after the strobe rises. The scoreboard matches every pulse against the strobe that caused it. A stuck synchronizer or mux register leaves the wrong byte on host_data_o after the settle window, and a selection sweep exposes it.

// File: rtl/pport_mbox_pkg.sv
package pport_mbox_pkg;
   typedef enum logic [1:0] {
      SRC_CHA  = 2'b00,
      SRC_CHB  = 2'b01,
      SRC_MBOX = 2'b10,
      SRC_ID   = 2'b11
   } src_e;

   localparam int unsigned CTRL_LINES = 4;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pport_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pport_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pport_mailbox.sv
module pport_mailbox #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [DATA_W-1:0] ctl_rdata
);
   logic              full_q;
   logic              by_host_q;
   logic [DATA_W-1:0] val_q;

   // Controller write has priority over a same-cycle host write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q    <= 1'b0;
         by_host_q <= 1'b0;
         val_q     <= '0;
      end else if (ctl_wr) begin
         full_q    <= 1'b1;
         by_host_q <= 1'b0;
         val_q     <= ctl_wdata;
      end else if (host_wr) begin
         full_q    <= 1'b1;
         by_host_q <= 1'b1;
         val_q     <= host_wdata;
      end
   end

   assign host_rdata = (full_q && !by_host_q) ? val_q : '0;
   assign ctl_rdata  = (full_q &&  by_host_q) ? val_q : '0;

   a_r3_host_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !ctl_wr) |=> (ctl_rdata == $past(host_wdata)) && (host_rdata == '0));

   a_r4_ctl_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (host_rdata == $past(ctl_wdata)) && (ctl_rdata == '0));

   a_r4_one_view_only: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata == '0) || (ctl_rdata == '0));

   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && !ctl_wr) |=> $stable(host_rdata) && $stable(ctl_rdata));
endmodule

// File: rtl/pport_data_mux.sv
module pport_data_mux
   import pport_mbox_pkg::*;
#(
   parameter int unsigned          DATA_W  = 8,
   parameter bit                   REG_OUT = 1'b1,
   parameter logic [DATA_W-1:0]    ID_BYTE = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  src_e              sel,
   input  logic [DATA_W-1:0] cha,
   input  logic [DATA_W-1:0] chb,
   input  logic [DATA_W-1:0] mbox,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      unique case (sel)
         SRC_CHA:  pick = cha;
         SRC_CHB:  pick = chb;
         SRC_MBOX: pick = mbox;
         default:  pick = ID_BYTE;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data <= '0;
         else        data <= pick;
      end
      a_r1_id_pattern: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == SRC_ID) |=> (data == ID_BYTE));
   end else begin : g_comb
      assign data = pick;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end
endmodule

// File: rtl/pport_mbox_mux.sv
module pport_mbox_mux
   import pport_mbox_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter bit                REG_OUT     = 1'b1,
   parameter logic [DATA_W-1:0] ID_BYTE     = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_alt_chan,
   input  logic              host_mbox_sel,
   input  logic              host_strobe,
   input  logic              host_dir_in,
   input  logic [DATA_W-1:0] host_data_i,
   output logic [DATA_W-1:0] host_data_o,
   output logic              host_data_oe,
   input  logic              scroll_mode,
   input  logic [DATA_W-1:0] cha_buf,
   input  logic [DATA_W-1:0] chb_buf,
   input  logic [DATA_W-1:0] cha_live,
   input  logic [DATA_W-1:0] chb_live,
   output logic              cha_adv,
   output logic              chb_adv,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   output logic [DATA_W-1:0] ctl_rdata
);
   if (DATA_W < 8) begin : g_bad_width
      $error("pport_mbox_mux: DATA_W must be at least 8");
   end

   localparam int unsigned CW = CTRL_LINES;

   logic [CW-1:0] ctrl_raw, ctrl_s;
   logic          s_alt, s_mbox, s_stb, s_dir;
   logic          stb_d;
   logic          stb_rise;
   src_e          sel;
   logic          host_wr;
   logic [DATA_W-1:0] host_view;
   logic [DATA_W-1:0] cha_src, chb_src;

   assign ctrl_raw = {host_dir_in, host_strobe, host_mbox_sel, host_alt_chan};

   pport_sync #(.WIDTH(CW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctrl_raw),
      .q     (ctrl_s)
   );

   assign {s_dir, s_stb, s_mbox, s_alt} = ctrl_s;
   assign sel = src_e'({s_mbox, s_alt});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_d <= 1'b0;
      else        stb_d <= s_stb;
   end
   assign stb_rise = s_stb && !stb_d;

   // Host data is sampled at the synchronized edge; the host holds it
   // stable across the strobe.
   assign host_wr = stb_rise && (sel == SRC_MBOX) && !s_dir;

   pport_mailbox #(.DATA_W(DATA_W)) u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_wdata (host_data_i),
      .ctl_wr     (ctl_wr),
      .ctl_wdata  (ctl_wdata),
      .host_rdata (host_view),
      .ctl_rdata  (ctl_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cha_adv <= 1'b0;
         chb_adv <= 1'b0;
      end else begin
         cha_adv <= stb_rise && (sel == SRC_CHA) && !scroll_mode;
         chb_adv <= stb_rise && (sel == SRC_CHB) && !scroll_mode;
      end
   end

   assign cha_src = scroll_mode ? cha_live : cha_buf;
   assign chb_src = scroll_mode ? chb_live : chb_buf;

   pport_data_mux #(.DATA_W(DATA_W), .REG_OUT(REG_OUT), .ID_BYTE(ID_BYTE)) u_mux (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .cha   (cha_src),
      .chb   (chb_src),
      .mbox  (host_view),
      .data  (host_data_o)
   );

   assign host_data_oe = s_dir;

   a_r6_adv_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cha_adv, chb_adv}));

   a_r9_adv_single_a: assert property (@(posedge clk) disable iff (!rst_n)
      cha_adv |=> !cha_adv);

   a_r9_adv_single_b: assert property (@(posedge clk) disable iff (!rst_n)
      chb_adv |=> !chb_adv);

   a_r7_no_adv_scroll: assert property (@(posedge clk) disable iff (!rst_n)
      (cha_adv || chb_adv) |-> $past(!scroll_mode));

   a_r8_no_adv_mbox: assert property (@(posedge clk) disable iff (!rst_n)
      $past(host_wr) |-> !(cha_adv || chb_adv));
endmodule

// File: tb/pport_mbox_mux_tb.sv
`timescale 1ns/1ps
module pport_mbox_mux_tb;
   localparam int DW = 8;
   localparam int SETTLE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_alt_chan = 0, host_mbox_sel = 0, host_strobe = 0, host_dir_in = 0;
   logic [DW-1:0] host_data_i = '0;
   logic [DW-1:0] host_data_o;
   logic          host_data_oe;
   logic          scroll_mode = 0;
   logic [DW-1:0] cha_buf = 8'h11, chb_buf = 8'h22, cha_live = 8'h33, chb_live = 8'h44;
   logic          cha_adv, chb_adv;
   logic          ctl_wr = 0;
   logic [DW-1:0] ctl_wdata = '0;
   logic [DW-1:0] ctl_rdata;

   int checks = 0;
   int fails  = 0;
   int exp_q[$];   // expected advance events: 1 = channel A, 2 = channel B

   always #2.5 clk = ~clk;

   pport_mbox_mux u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_alt_chan(host_alt_chan), .host_mbox_sel(host_mbox_sel),
      .host_strobe(host_strobe), .host_dir_in(host_dir_in),
      .host_data_i(host_data_i), .host_data_o(host_data_o), .host_data_oe(host_data_oe),
      .scroll_mode(scroll_mode),
      .cha_buf(cha_buf), .chb_buf(chb_buf), .cha_live(cha_live), .chb_live(chb_live),
      .cha_adv(cha_adv), .chb_adv(chb_adv),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected event for every advance pulse seen.
   always @(negedge clk) begin
      if (rst_n && (cha_adv || chb_adv)) begin
         int got;
         got = cha_adv ? 1 : 2;
         if (exp_q.size() == 0) begin
            check(1'b0, "R6/R7/R8 unexpected advance", got, 0);
         end else begin
            int want;
            want = exp_q.pop_front();
            check(got == want, "R6 advance channel", got, want);
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sel(input logic mbox, input logic alt, input logic dir);
      @(negedge clk);
      host_mbox_sel = mbox;
      host_alt_chan = alt;
      host_dir_in   = dir;
      wait_cyc(SETTLE);
   endtask

   // Driver: pushes the expected event (0 = none) then pulses the strobe.
   task automatic strobe(input int expect_ev, input int width);
      if (expect_ev != 0) exp_q.push_back(expect_ev);
      @(negedge clk);
      host_strobe = 1'b1;
      wait_cyc(width);
      host_strobe = 1'b0;
      wait_cyc(SETTLE);
   endtask

   task automatic ctl_write(input logic [DW-1:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
      wait_cyc(2);
   endtask

   initial begin : watchdog
      #(5ns * 100000);
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);
      // R5 / R2 reset state
      check(ctl_rdata == 8'h00, "R5 ctl view empty", ctl_rdata, 0);
      check(host_data_oe == 1'b0, "R2 oe low after reset", host_data_oe, 0);

      set_sel(1'b1, 1'b0, 1'b1);
      check(host_data_o == 8'h00, "R5 host view empty", host_data_o, 0);
      check(host_data_oe == 1'b1, "R2 oe high when released", host_data_oe, 1);

      // R1 selection sweep
      set_sel(1'b0, 1'b0, 1'b1);
      check(host_data_o == 8'h11, "R1 chA", host_data_o, 8'h11);
      set_sel(1'b0, 1'b1, 1'b1);
      check(host_data_o == 8'h22, "R1 chB", host_data_o, 8'h22);
      set_sel(1'b1, 1'b1, 1'b1);
      check(host_data_o == 8'h55, "R1 id byte", host_data_o, 8'h55);

      // R1 latency bound: SYNC_STAGES+1 = 3 cycles
      @(negedge clk);
      host_mbox_sel = 1'b0; host_alt_chan = 1'b0;
      wait_cyc(3);
      check(host_data_o == 8'h11, "R1 latency", host_data_o, 8'h11);
      wait_cyc(SETTLE);

      // R3 host write
      set_sel(1'b1, 1'b0, 1'b0);
      check(host_data_oe == 1'b0, "R2 oe low while host drives", host_data_oe, 0);
      host_data_i = 8'hA5;
      strobe(0, 2);
      check(ctl_rdata == 8'hA5, "R3 ctl sees host byte", ctl_rdata, 8'hA5);
      set_sel(1'b1, 1'b0, 1'b1);
      check(host_data_o == 8'h00, "R3 host reads own write as 0", host_data_o, 0);

      // R4 controller write
      ctl_write(8'h3C);
      check(ctl_rdata == 8'h00, "R4 ctl reads own write as 0", ctl_rdata, 0);
      wait_cyc(SETTLE);
      check(host_data_o == 8'h3C, "R4 host sees ctl byte", host_data_o, 8'h3C);

      // R8 strobe with mailbox selected but host released: no change
      host_data_i = 8'h77;
      strobe(0, 2);
      check(ctl_rdata == 8'h00, "R8 no write when released", ctl_rdata, 0);
      check(host_data_o == 8'h3C, "R8 host view kept", host_data_o, 8'h3C);

      // R8 strobe on id selection, host driving
      set_sel(1'b1, 1'b1, 1'b0);
      strobe(0, 2);
      set_sel(1'b1, 1'b0, 1'b1);
      check(host_data_o == 8'h3C, "R8 id strobe no mailbox change", host_data_o, 8'h3C);
      check(ctl_rdata == 8'h00, "R8 id strobe ctl view", ctl_rdata, 0);

      // R6 advance pulses
      set_sel(1'b0, 1'b0, 1'b1);
      strobe(1, 1);
      strobe(1, 3);
      set_sel(1'b0, 1'b1, 1'b1);
      strobe(2, 2);
      // R9 long strobe gives one pulse
      strobe(2, 40);

      // R7 scroll mode
      @(negedge clk); scroll_mode = 1'b1;
      set_sel(1'b0, 1'b0, 1'b1);
      check(host_data_o == 8'h33, "R7 live chA", host_data_o, 8'h33);
      strobe(0, 2);
      set_sel(1'b0, 1'b1, 1'b1);
      check(host_data_o == 8'h44, "R7 live chB", host_data_o, 8'h44);
      strobe(0, 2);
      @(negedge clk); scroll_mode = 1'b0;
      wait_cyc(SETTLE);
      check(host_data_o == 8'h22, "R7 back to buffered", host_data_o, 8'h22);

      // R4 simultaneous write: controller kept
      set_sel(1'b1, 1'b0, 1'b0);
      host_data_i = 8'h99;
      @(negedge clk);
      host_strobe = 1'b1;
      wait_cyc(2);
      ctl_wr = 1'b1; ctl_wdata = 8'h5A;   // host_wr fires at this edge
      @(negedge clk);
      ctl_wr = 1'b0;
      host_strobe = 1'b0;
      wait_cyc(SETTLE);
      set_sel(1'b1, 1'b0, 1'b1);
      check(host_data_o == 8'h5A, "R4 controller priority", host_data_o, 8'h5A);
      check(ctl_rdata == 8'h00, "R4 controller priority ctl view", ctl_rdata, 0);

      wait_cyc(SETTLE);
      check(exp_q.size() == 0, "R6/R9 all expected advances seen", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule